// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block turns a stereo serial audio stream into parallel sample words. The stream is carried on three lines: a word-select clock that tells the two channels apart, a bit clock, and a data line. All three are sampled by the system clock, which must be fast enough to see every bit-clock level. A run-time format code picks one of three framings and the level of the word-select clock that marks the left channel. The framings are right-justified with the MSB first, right-justified with the LSB first, and I2S.

Each channel half is turned into a 24-bit word. When a complete stereo frame has been received, the block updates its left and right outputs. In the same system clock cycle it raises a one-cycle valid pulse. Changing the format code at any time restarts frame alignment. The partly received frame is dropped.

Top module: `serial_audio_rx`

## Requirements
- R1: Out of reset, both sample words are zero, valid is low and the stored format code is 000.
- R2: Code 000: data is sampled on rising bit-clock edges, MSB first. The left channel is the half where the word-select clock is high. The sample is the last 24 bits received before the word-select transition that ends the half, and earlier pad bits are dropped.
- R3: Code 001 is the same as R2, except that the first of the last 24 bits is the LSB and the final bit is the MSB.
- R4: Code 010 is I2S. The MSB is taken on the second rising bit-clock edge after a word-select transition, with 23 more bits following MSB first. Any bits after those 24 are ignored. The left channel is the half where the word-select clock is high.
- R5: Format bit 2 set to 1 keeps the framing chosen by bits 1:0 but makes the word-select-low half the left channel.
- R6: Codes 011 and 111 are reserved. With a reserved code, valid is never raised and both output words keep their previous values.
- R7: One stereo frame is a left half followed by a right half. The right half is complete at the next word-select transition. Valid is then high for exactly one cycle, and both words change only in the cycle where valid is high.
- R8: A change of format code resets frame alignment. The first bit-clock edge after the change only records the word-select level. The next word-select transition only aligns. No valid is raised for any half that began before alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_code | input | 3 | Format code: bits 1:0 framing, bit 2 left-channel polarity |
| lrck_in | input | 1 | Word-select clock, asynchronous |
| bclk_in | input | 1 | Bit clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| left_word | output | WORD_W | Last left sample |
| right_word | output | WORD_W | Last right sample |
| frame_valid | output | 1 | One-cycle pulse when a new stereo pair is presented |

## Verification
Suppose the shift register or the bit counter goes wrong. The damage shows in the very next word presented, as shifted, reversed or pad-polluted bits, about one half-frame after the fault. If the channel-assignment state goes wrong, the left and right words come out swapped, or a frame gets a pulse when none is due. Both faults appear at the first word-select transition that ends a right half. If the alignment state survives a format change, a pulse appears within two word-select transitions of the change. This is where the bench waits for silence.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  typedef enum logic [1:0] {
    FR_RJ_MSB = 2'b00,
    FR_RJ_LSB = 2'b01,
    FR_I2S    = 2'b10,
    FR_RSVD   = 2'b11
  } framing_e;

  typedef enum logic [1:0] {
    AL_IDLE  = 2'b00,
    AL_ALIGN = 2'b01,
    AL_RUN   = 2'b10
  } align_e;

  function automatic framing_e framing_of(input logic [2:0] code);
    return framing_e'(code[1:0]);
  endfunction

  // level of the word-select clock that marks the left half
  function automatic logic left_level_of(input logic [2:0] code);
    return ~code[2];
  endfunction

  function automatic logic is_reserved(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic sdata_in,
  output logic bclk_rise,
  output logic lr_s,
  output logic data_s
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain [STAGES];
  logic            bclk_last;

  assign raw = {bclk_in, lrck_in, sdata_in};

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_last <= 1'b0;
    else        bclk_last <= chain[STAGES-1][2];
  end

  assign bclk_rise = chain[STAGES-1][2] & ~bclk_last;
  assign lr_s      = chain[STAGES-1][1];
  assign data_s    = chain[STAGES-1][0];

endmodule

// File: rtl/sarx_shifter.sv
module sarx_shifter
  import sarx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_en,
  input  logic              lr_edge,
  input  framing_e          framing,
  input  logic              din,
  output logic [WORD_W-1:0] half_word
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_TOP = WORD_W + 1;

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;

  // first bit of a new half
  function automatic logic [WORD_W-1:0] seed_word(input framing_e fr, input logic d);
    logic [WORD_W-1:0] w;
    w = '0;
    case (fr)
      FR_RJ_LSB: w[WORD_W-1] = d;
      FR_I2S:    w = '0;
      default:   w[0] = d;
    endcase
    return w;
  endfunction

  // one further bit inside the current half
  function automatic logic [WORD_W-1:0] step_word(input framing_e fr,
                                                  input logic [WORD_W-1:0] cur,
                                                  input logic d,
                                                  input logic [CNT_W-1:0] idx);
    logic [WORD_W-1:0] w;
    case (fr)
      FR_RJ_LSB: w = {d, cur[WORD_W-1:1]};
      FR_I2S: begin
        if (idx >= CNT_W'(1) && idx <= CNT_W'(WORD_W)) w = {cur[WORD_W-2:0], d};
        else                                           w = cur;
      end
      default:   w = {cur[WORD_W-2:0], d};
    endcase
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (bit_en) begin
      if (lr_edge) begin
        shreg   <= seed_word(framing, din);
        bit_idx <= CNT_W'(1);
      end else begin
        shreg   <= step_word(framing, shreg, din, bit_idx);
        if (bit_idx != CNT_W'(CNT_TOP)) bit_idx <= bit_idx + CNT_W'(1);
      end
    end
  end

  assign half_word = shreg;

endmodule

// File: rtl/sarx_frame_ctl.sv
module sarx_frame_ctl
  import sarx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bclk_rise,
  input  logic              lr_s,
  input  logic              left_lvl,
  input  logic              reserved,
  input  logic [WORD_W-1:0] half_word,
  output logic              lr_edge,
  output logic              left_done,
  output logic              right_done,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              frame_valid
);
  align_e            st;
  logic              lr_last;
  logic              have_left;
  logic [WORD_W-1:0] left_hold;

  assign lr_edge    = bclk_rise && (st != AL_IDLE) && (lr_s != lr_last);
  assign left_done  = lr_edge && (st == AL_RUN) && (lr_last == left_lvl);
  assign right_done = lr_edge && (st == AL_RUN) && (lr_last != left_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= AL_IDLE;
      lr_last     <= 1'b0;
      have_left   <= 1'b0;
      left_hold   <= '0;
      left_word   <= '0;
      right_word  <= '0;
      frame_valid <= 1'b0;
    end else if (clear) begin
      st          <= AL_IDLE;
      have_left   <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bclk_rise) begin
        lr_last <= lr_s;
        case (st)
          AL_IDLE:  st <= AL_ALIGN;
          AL_ALIGN: if (lr_edge) st <= AL_RUN;
          default: begin
            if (left_done) begin
              left_hold <= half_word;
              have_left <= 1'b1;
            end else if (right_done) begin
              have_left <= 1'b0;
              if (have_left && !reserved) begin
                left_word   <= left_hold;
                right_word  <= half_word;
                frame_valid <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_code,
  input  logic              lrck_in,
  input  logic              bclk_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              frame_valid
);
  logic [2:0]        fmt_q;
  logic              fmt_change;
  logic              fmt_reserved;
  logic              bclk_rise;
  logic              lr_s;
  logic              data_s;
  logic              lr_edge;
  logic              left_done;
  logic              right_done;
  logic [WORD_W-1:0] half_word;

  assign fmt_change   = (fmt_code != fmt_q);
  assign fmt_reserved = is_reserved(fmt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= 3'b000;
    else        fmt_q <= fmt_code;
  end

  sarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .lrck_in   (lrck_in),
    .sdata_in  (sdata_in),
    .bclk_rise (bclk_rise),
    .lr_s      (lr_s),
    .data_s    (data_s)
  );

  sarx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (fmt_change),
    .bit_en    (bclk_rise),
    .lr_edge   (lr_edge),
    .framing   (framing_of(fmt_q)),
    .din       (data_s),
    .half_word (half_word)
  );

  sarx_frame_ctl #(.WORD_W(WORD_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (fmt_change),
    .bclk_rise   (bclk_rise),
    .lr_s        (lr_s),
    .left_lvl    (left_level_of(fmt_q)),
    .reserved    (fmt_reserved),
    .half_word   (half_word),
    .lr_edge     (lr_edge),
    .left_done   (left_done),
    .right_done  (right_done),
    .left_word   (left_word),
    .right_word  (right_word),
    .frame_valid (frame_valid)
  );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic [WORD_W-1:0] left_word,
  input logic [WORD_W-1:0] right_word,
  input logic              bclk_rise,
  input logic              lr_edge,
  input logic              right_done,
  input logic              fmt_change,
  input logic              fmt_reserved
);

  p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_valid_after_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(right_done));

  p_words_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(left_word) && $stable(right_word)));

  p_reserved_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_reserved && !fmt_change) |=> !frame_valid);

  p_change_discards_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_change |=> !frame_valid);

  p_edge_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lr_edge |-> bclk_rise);

endmodule

bind serial_audio_rx sarx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_valid  (frame_valid),
  .left_word    (left_word),
  .right_word   (right_word),
  .bclk_rise    (bclk_rise),
  .lr_edge      (lr_edge),
  .right_done   (right_done),
  .fmt_change   (fmt_change),
  .fmt_reserved (fmt_reserved)
);

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  localparam int W    = 24;
  localparam int HALF = 32;
  localparam int NVEC = 8;

  // {fmt, left, right}
  localparam logic [50:0] VEC [NVEC] = '{
    {3'b000, 24'h123456, 24'hABCDEF},
    {3'b001, 24'h800001, 24'h7FFFFE},
    {3'b010, 24'hC35A96, 24'h0F0F0F},
    {3'b100, 24'hFEDCBA, 24'h012345},
    {3'b101, 24'hA5A5A5, 24'h5A5A5A},
    {3'b110, 24'h800000, 24'h000001},
    {3'b011, 24'h111111, 24'h222222},
    {3'b111, 24'h333333, 24'h444444}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt_code = 3'b000;
  logic lrck = 1'b0, bclk = 1'b0, sdata = 1'b0;
  logic [W-1:0] left_word, right_word;
  logic frame_valid;

  int n_chk = 0, n_fail = 0;
  int pulses = 0;
  logic [W-1:0] got_l, got_r;
  logic was_valid = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code),
    .lrck_in(lrck), .bclk_in(bclk), .sdata_in(sdata),
    .left_word(left_word), .right_word(right_word), .frame_valid(frame_valid)
  );

  always @(negedge clk) begin
    if (frame_valid) begin
      pulses++;
      got_l = left_word;
      got_r = right_word;
      if (was_valid) begin
        n_chk++; n_fail++;
        $display("FAIL R7: valid high two cycles, got 1 expected 0");
      end
    end
    was_valid = frame_valid;
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] f);
    if (f[1:0] == 2'b11) return "R6";
    if (f[2]) return "R5";
    case (f[1:0])
      2'b00: return "R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  // bit transmitted at position i of a half, restating the framings
  function automatic logic tx_bit(input logic [2:0] f, input logic [W-1:0] w, input int i);
    case (f[1:0])
      2'b01:   return (i < HALF - W) ? 1'b1 : w[i - (HALF - W)];
      2'b10:   return (i >= 1 && i <= W) ? w[W - i] : 1'b1;
      default: return (i < HALF - W) ? 1'b1 : w[HALF - 1 - i];
    endcase
  endfunction

  task automatic send_half(input logic [2:0] f, input logic lvl, input logic [W-1:0] w);
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      lrck  = lvl;
      sdata = tx_bit(f, w, i);
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic set_fmt(input logic [2:0] f);
    @(negedge clk);
    fmt_code = f;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 left", left_word, '0);
    check("R1 right", right_word, '0);
    check("R1 valid", W'(frame_valid), '0);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] f;
      logic [W-1:0] l, r;
      logic lft;
      int exp_n;
      f = VEC[v][50:48]; l = VEC[v][47:24]; r = VEC[v][23:0];
      lft = ~f[2];
      exp_n = (f[1:0] == 2'b11) ? 0 : 1;
      set_fmt(f == 3'b011 ? 3'b111 : 3'b011);
      set_fmt(f);
      pulses = 0;
      send_half(f, ~lft, 24'hAAAAAA);
      send_half(f, lft, l);
      send_half(f, ~lft, r);
      send_half(f, lft, 24'h555555);
      repeat (16) @(negedge clk);
      check({tag_of(f), " R7 pulse count"}, W'(pulses), W'(exp_n));
      if (exp_n == 1) begin
        check({tag_of(f), " left"}, got_l, l);
        check({tag_of(f), " right"}, got_r, r);
      end
    end
    // R6: outputs keep last valid pair after reserved codes
    check("R6 left held", left_word, 24'h800000);
    check("R6 right held", right_word, 24'h000001);

    // R8: format change in mid-frame discards it, then re-aligns
    set_fmt(3'b011);
    set_fmt(3'b000);
    pulses = 0;
    send_half(3'b000, 1'b0, 24'hAAAAAA);
    send_half(3'b000, 1'b1, 24'h111111);
    set_fmt(3'b100);
    set_fmt(3'b000);
    send_half(3'b000, 1'b0, 24'h222222);
    send_half(3'b000, 1'b1, 24'h666666);
    repeat (16) @(negedge clk);
    check("R8 no pulse for discarded frame", W'(pulses), '0);
    send_half(3'b000, 1'b0, 24'h777777);
    send_half(3'b000, 1'b1, 24'h555555);
    repeat (16) @(negedge clk);
    check("R8 pulse after realign", W'(pulses), W'(1));
    check("R8 left after realign", got_l, 24'h666666);
    check("R8 right after realign", got_r, 24'h777777);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule